// File: doc/BRIEF.md
# Dual-Depth Stereo Sample FIFO with Crossing Mute

This block sits between two sample streams that run at unrelated rates. The producer pushes one stereo sample, a left and a right word, with a write strobe. The consumer pulls one stereo sample with a read strobe. Both strobes are enables in the block's single clock domain. A depth-mode input picks one of two operating depths. The short depth keeps latency low. The long depth rides out larger swings in the rate ratio. Both depths share one memory sized for the long depth.

The block tracks how many samples it holds. A read from an empty buffer is an underflow. A write into a full buffer with no read in the same cycle is an overflow. Either event means the read and write pointers have crossed. The block then raises its mute output and places the read pointer half the active depth behind the write pointer. Mute stays high for a fixed number of read strobes, and every sample read while muted comes out as zero. A change of the synchronised mode input re-centres and mutes in the same way, because the data left in the buffer no longer matches the new depth.

Top module: `dual_depth_smp_fifo`

## Requirements
- R1: While reset is low and in the first cycle after it, mute is low, both read outputs are zero and the buffer is empty.
- R2: Outside a crossing, samples are read back in the order they were written, left and right words unchanged, and each read output holds its value until the next read strobe.
- R3: A write strobe with no read strobe while the buffer holds the active depth (32 in short mode, 128 in long mode) is an overflow crossing, and mute is high after that clock edge.
- R4: A read strobe while the buffer is empty is an underflow crossing, and mute is high after that clock edge.
- R5: After a crossing, mute stays high for exactly 128 read strobes and falls after the edge that takes the 128th. Cycles with no read strobe do not shorten the mute.
- R6: A read strobe taken while mute is high, or in the crossing cycle itself, sets both read outputs to zero.
- R7: Right after a crossing the buffer holds exactly half the active depth: 64 samples in long mode, 16 in short mode.
- R8: A crossing while mute is already high restarts the count, so mute then lasts a further 128 read strobes.
- R9: The mode input passes through two flops. A change is applied at the third rising edge after it is presented. Applying it re-centres the buffer to half the new depth and starts a 128-read mute.
- R10: Mode encoding: mode input 1 selects the short depth of 32 and 0 selects the long depth of 128. Reset selects the long depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_short_i | input | 1 | Depth mode: 1 short, 0 long; may be asynchronous |
| wr_en_i | input | 1 | Write strobe, one stereo sample per cycle |
| wr_left_i | input | DATA_W | Left word to write |
| wr_right_i | input | DATA_W | Right word to write |
| rd_en_i | input | 1 | Read strobe, one stereo sample per cycle |
| rd_left_o | output | DATA_W | Left word of the last read |
| rd_right_o | output | DATA_W | Right word of the last read |
| mute_o | output | 1 | High while samples are being muted after a crossing or mode change |

## Verification
Read data, mute and occupancy all change at the edge that takes the strobe, so every result is due one cycle after its stimulus. The exception is the mode input, which takes effect only at the third edge. The bench drives inputs on falling edges, advances its queue model on the rising edge, and compares both outputs on the next falling edge. This lands each check exactly one edge after the strobe that caused it. Directed checks count strobes instead of cycles: 128 reads of mute, 65 or 17 writes to overflow, 65 or 17 reads to underflow. Mute is sampled before every strobe, so a count that is off by one edge shows up as a wrong total.

// File: rtl/ddf_pkg.sv
package ddf_pkg;

    // Depth selection as seen after synchronisation.
    typedef enum logic {
        MODE_LONG  = 1'b0,
        MODE_SHORT = 1'b1
    } ddf_mode_e;

endpackage

// File: rtl/ddf_sync.sv
module ddf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ddf_mem.sv
module ddf_mem #(
    parameter int unsigned WIDTH = 48,
    parameter int unsigned DEPTH = 128,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WIDTH-1:0]  rdata_o
);

    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) store_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = store_q[raddr_i];

endmodule

// File: rtl/dual_depth_smp_fifo.sv
module dual_depth_smp_fifo
    import ddf_pkg::*;
#(
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned SHORT_DEPTH = 32,
    parameter int unsigned LONG_DEPTH  = 128,
    parameter int unsigned MUTE_LEN    = 128,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_short_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_left_i,
    input  logic [DATA_W-1:0] wr_right_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_left_o,
    output logic [DATA_W-1:0] rd_right_o,
    output logic              mute_o
);

    localparam int unsigned PTR_W = $clog2(LONG_DEPTH);
    localparam int unsigned LVL_W = $clog2(LONG_DEPTH + 1);
    localparam int unsigned CNT_W = $clog2(MUTE_LEN + 1);
    localparam int unsigned SMP_W = 2 * DATA_W;

    typedef struct packed {
        logic [PTR_W-1:0]  wp;
        logic [PTR_W-1:0]  rp;
        logic [LVL_W-1:0]  lvl;
        logic [CNT_W-1:0]  cnt;
        ddf_mode_e         mode;
        logic [DATA_W-1:0] out_l;
        logic [DATA_W-1:0] out_r;
    } state_t;

    localparam state_t RESET_STATE = '0;

    function automatic logic [LVL_W-1:0] depth_of(input ddf_mode_e m);
        return (m == MODE_SHORT) ? LVL_W'(SHORT_DEPTH) : LVL_W'(LONG_DEPTH);
    endfunction

    state_t            s_d, s_q;
    logic              mode_sync;
    logic [SMP_W-1:0]  mem_rd;

    logic [LVL_W-1:0]  cur_depth, new_depth;
    logic [PTR_W-1:0]  cur_mask, new_mask, wp_adv;
    logic              mode_chg, under, over, clean;

    ddf_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (mode_short_i),
        .sync_o  (mode_sync)
    );

    ddf_mem #(.WIDTH(SMP_W), .DEPTH(LONG_DEPTH)) i_mem (
        .clk_i   (clk_i),
        .we_i    (wr_en_i),
        .waddr_i (s_q.wp),
        .wdata_i ({wr_left_i, wr_right_i}),
        .raddr_i (s_q.rp),
        .rdata_o (mem_rd)
    );

    always_comb begin
        s_d       = s_q;
        cur_depth = depth_of(s_q.mode);
        new_depth = depth_of(ddf_mode_e'(mode_sync));
        cur_mask  = PTR_W'(cur_depth - 1'b1);
        new_mask  = PTR_W'(new_depth - 1'b1);
        mode_chg  = (ddf_mode_e'(mode_sync) != s_q.mode);
        under     = rd_en_i && (s_q.lvl == '0);
        over      = wr_en_i && !rd_en_i && (s_q.lvl == cur_depth);
        clean     = (s_q.cnt == '0) && !under && !over && !mode_chg;
        wp_adv    = wr_en_i ? ((s_q.wp + 1'b1) & cur_mask) : s_q.wp;
        s_d.wp    = wp_adv;

        if (rd_en_i) begin
            s_d.out_l = clean ? mem_rd[SMP_W-1:DATA_W] : '0;
            s_d.out_r = clean ? mem_rd[DATA_W-1:0]     : '0;
        end

        if (mode_chg) begin
            s_d.mode = ddf_mode_e'(mode_sync);
            s_d.wp   = wp_adv & new_mask;
            s_d.rp   = (s_d.wp - PTR_W'(new_depth >> 1)) & new_mask;
            s_d.lvl  = new_depth >> 1;
            s_d.cnt  = CNT_W'(MUTE_LEN);
        end else if (under || over) begin
            s_d.rp   = (wp_adv - PTR_W'(cur_depth >> 1)) & cur_mask;
            s_d.lvl  = cur_depth >> 1;
            s_d.cnt  = CNT_W'(MUTE_LEN);
        end else begin
            if (rd_en_i) s_d.rp = (s_q.rp + 1'b1) & cur_mask;
            s_d.lvl = s_q.lvl + LVL_W'(wr_en_i) - LVL_W'(rd_en_i);
            if (rd_en_i && (s_q.cnt != '0)) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= RESET_STATE;
        else         s_q <= s_d;
    end

    assign rd_left_o  = s_q.out_l;
    assign rd_right_o = s_q.out_r;
    assign mute_o     = (s_q.cnt != '0);

    // R3
    level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.lvl <= cur_depth);

    // R4
    underflow_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && s_q.lvl == '0) |=> mute_o);

    // R6
    muted_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && mute_o) |=> (rd_left_o == '0 && rd_right_o == '0));

    // R5
    mute_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mute_o) |-> $past(rd_en_i));

    // R7
    recentre_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mute_o) |-> (s_q.lvl == (cur_depth >> 1)));

    // R9
    mode_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.mode) |-> (s_q.cnt == CNT_W'(MUTE_LEN)));

endmodule

// File: tb/test_dual_depth_smp_fifo.sv
module test_dual_depth_smp_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int WATCHDOG   = 60000;

    logic          clk = 1'b0, rst_n = 1'b0, mode_s = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [DW-1:0] wl = '0, wrr = '0;
    logic [DW-1:0] rd_l, rd_r;
    logic          mute;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_depth_smp_fifo i_dual_depth_smp_fifo (
        .clk_i(clk), .rst_ni(rst_n), .mode_short_i(mode_s),
        .wr_en_i(wr), .wr_left_i(wl), .wr_right_i(wrr),
        .rd_en_i(rd), .rd_left_o(rd_l), .rd_right_o(rd_r), .mute_o(mute)
    );

    typedef struct { bit known; logic [DW-1:0] l; logic [DW-1:0] r; } ent_t;

    ent_t              mq[$];
    logic [2*DW-1:0]   hist[$];
    int                cnt_m = 0;
    bit                mode_m = 0, s1_m = 0, s2_m = 0;
    logic [DW-1:0]     exp_l = '0, exp_r = '0;
    bit                exp_known = 1;
    int                errors = 0, checks = 0, cycles = 0;
    int unsigned       seq = 1;
    string             tag = "R1";

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic rebuild(int half);
        mq.delete();
        for (int i = 0; i < half; i++) begin
            int idx = hist.size() - half + i;
            if (idx >= 0) mq.push_back('{1'b1, hist[idx][2*DW-1:DW], hist[idx][DW-1:0]});
            else          mq.push_back('{1'b0, '0, '0});
        end
    endtask

    task automatic model_update();
        int depth = mode_m ? 32 : 128;
        bit chg   = (s2_m != mode_m);
        bit unf   = rd && (mq.size() == 0);
        bit ovf   = wr && !rd && (mq.size() == depth);
        bit mut   = (cnt_m != 0) || chg || unf || ovf;
        ent_t e;
        if (rd) begin
            e = '{1'b1, '0, '0};
            if (mq.size() > 0) e = mq.pop_front();
            if (mut) begin exp_l = '0; exp_r = '0; exp_known = 1; end
            else begin exp_l = e.l; exp_r = e.r; exp_known = e.known; end
        end
        if (wr) begin
            hist.push_back({wl, wrr});
            if (hist.size() > 128) void'(hist.pop_front());
            if (!chg && !unf && !ovf) mq.push_back('{1'b1, wl, wrr});
        end
        if (chg) begin
            mode_m = s2_m;
            hist.delete();
            mq.delete();
            for (int i = 0; i < (mode_m ? 16 : 64); i++) mq.push_back('{1'b0, '0, '0});
            cnt_m = 128;
        end else if (unf || ovf) begin
            rebuild(depth / 2);
            cnt_m = 128;
        end else if (rd && cnt_m != 0) begin
            cnt_m--;
        end
        s2_m = s1_m;
        s1_m = mode_s;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); hist.delete();
            cnt_m = 0; mode_m = 0; s1_m = 0; s2_m = 0;
            exp_l = '0; exp_r = '0; exp_known = 1;
        end else begin
            model_update();
        end
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog %s actual=%0d cycles expected<%0d", tag, cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic compare();
        chk(mute == (cnt_m != 0), tag, "mute", mute, cnt_m != 0);
        if (exp_known) begin
            chk(rd_l == exp_l, tag, "left", rd_l, exp_l);
            chk(rd_r == exp_r, tag, "right", rd_r, exp_r);
        end
    endtask

    task automatic step(bit w, bit r);
        wr = w; rd = r;
        if (w) begin wl = DW'(seq); wrr = ~DW'(seq); seq++; end
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    int n;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mute == 1'b0 && rd_l == '0 && rd_r == '0, "R1", "reset outputs", {mute, rd_l}, 0);
        rst_n = 1'b1;
        step(0, 0);
        chk(mute == 1'b0 && rd_l == '0, "R1", "after reset", mute, 0);

        // R2: ordered flow in long mode
        tag = "R2";
        repeat (50) step(1, 0);
        repeat (60) step(1, 1);
        while (mq.size() > 0) step(0, 1);

        // R4: underflow
        tag = "R4";
        step(0, 1);
        chk(mute == 1'b1, "R4", "mute after empty read", mute, 1);

        // R5 / R6: mute length, zero output
        tag = "R6";
        n = 0;
        while (mute && n < 1000) begin step(1, 1); n++; end
        chk(n == 128, "R5", "reads while muted", n, 128);

        // R3 / R7 / R10: long depth from reset, half level after recentre
        tag = "R3";
        n = 0;
        while (!mute && n < 1000) begin step(1, 0); n++; end
        chk(n == 65, "R3", "writes to overflow long", n, 65);
        chk(n == 65, "R7", "level 64 after underflow", n, 65);
        chk(n == 65, "R10", "reset selects long depth", n, 65);

        // R8: crossing during mute restarts the count
        tag = "R8";
        repeat (50) step(1, 1);
        repeat (65) step(0, 1);
        n = 0;
        while (mute && n < 1000) begin step(1, 1); n++; end
        chk(n == 128, "R8", "restarted mute length", n, 128);

        // R9: mode change through two flops
        tag = "R9";
        mode_s = 1'b1;
        step(0, 0);
        chk(mute == 1'b0, "R9", "edge 1 no change", mute, 0);
        step(0, 0);
        chk(mute == 1'b0, "R9", "edge 2 no change", mute, 0);
        step(0, 0);
        chk(mute == 1'b1, "R9", "edge 3 applied", mute, 1);
        n = 0;
        while (mute && n < 1000) begin step(1, 1); n++; end
        chk(n == 128, "R9", "mode change mute length", n, 128);

        // R3 / R7 / R10 in short mode
        tag = "R3";
        n = 0;
        while (!mute && n < 1000) begin step(1, 0); n++; end
        chk(n == 17, "R3", "writes to overflow short", n, 17);
        chk(n == 17, "R10", "mode 1 selects depth 32", n, 17);
        tag = "R6";
        n = 0;
        while (mute && n < 1000) begin step(1, 1); n++; end
        chk(n == 128, "R5", "short mode mute length", n, 128);
        tag = "R7";
        n = 0;
        while (!mute && n < 1000) begin step(0, 1); n++; end
        chk(n == 17, "R7", "reads to underflow from 16", n, 17);

        // R9: back to long
        tag = "R9";
        n = 0;
        while (mute && n < 1000) begin step(1, 1); n++; end
        mode_s = 1'b0;
        step(0, 0); step(0, 0); step(0, 0);
        chk(mute == 1'b1, "R9", "return to long mutes", mute, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule